// File: doc/BRIEF.md
# Serial Register Access Port

This block is a slave serial control port that lets a host read and write a bank of 8-bit registers with 5-bit addresses. It uses four wires: an active-low select, a serial clock, a data input and a data output that can be released. The serial lines come in asynchronously. They are oversampled into the system clock through synchronizer stages, and serial clock edges are detected from the synchronized copy.

Each transfer is a 16-bit frame sent MSB first:
- a 2-bit chip address,
- a direction bit (1 = write, 0 = read),
- a 5-bit register address,
- 8 data bits.

For a write, the block issues a one-cycle write strobe with the address and data once the last bit has arrived. For a read, it issues a one-cycle read-request strobe once the header is complete. It captures the value the attached bank returns in that same cycle, and shifts that value out on the falling serial clock edges of the data phase.

Top module: `sctl_port`

## Requirements
- R1: Frame bits are, in order: chip address C1..C0 (frame bits 15..14), direction (bit 13), address A4..A0 (bits 12..8), data D7..D0 (bits 7..0), each captured on a rising serial clock edge while select is low. No write strobe is issued before the 16th rising edge. The strobe follows that edge within SYNC_STAGES+2 system clocks and carries the frame's address and data.
- R2: A frame whose chip address is not 00 produces no write strobe, no read strobe and no output drive.
- R3: Direction bit 1 selects a write and 0 selects a read. A read with chip address 00 raises `rd_stb` for exactly one cycle after the 8th rising edge, with `rd_addr` equal to A4..A0. A read never raises `wr_stb`.
- R4: In a read, the register value appears on `sdo` MSB first. One bit is shifted out on each falling edge, starting with the first falling edge after the 8th rising edge, so D7 is valid at the 9th rising edge and D0 at the 16th.
- R5: `sdo_oe` is low during the header phase of every frame and during all of a write frame. It returns low within SYNC_STAGES+1 system clocks of select going high.
- R6: Writes to addresses above TOP_WRITABLE (default 11h, so 12h..1Fh) are suppressed. Address 11h itself is writable.
- R7: If select rises before the 16th rising edge, the frame is dropped with no write strobe.
- R8: Each frame produces at most one write strobe. Rising edges beyond the 16th are ignored.
- R9: After reset, `wr_stb`, `rd_stb` and `sdo_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low, idles high |
| sck | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial read data to host |
| sdo_oe | output | 1 | Output enable for sdo; low means high impedance |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | AW | Write address |
| wr_data | output | DW | Write data |
| rd_stb | output | 1 | One-cycle read request |
| rd_addr | output | AW | Read address |
| rd_data | input | DW | Register value, valid in the rd_stb cycle |

## Verification
A bit counter that is off by one or not cleared by select shows up as a misplaced strobe. The strobe either fires before the 16th rising edge, or it fires after an aborted frame. The bench looks for it within a few system clocks of the edge in question. A bad header latch shows up at once as a wrong address on a strobe, or as a strobe for a foreign chip address. A slip in the read shifter shows up as a rotated byte on `sdo` inside the same frame. An enable left stuck high is visible within SYNC_STAGES+1 clocks of select rising.

// File: rtl/sctl_port.sv
module sctl_port #(
  parameter int SYNC_STAGES  = 2,
  parameter int CW           = 2,
  parameter int AW           = 5,
  parameter int DW           = 8,
  parameter int CHIP_ID      = 0,
  parameter int TOP_WRITABLE = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          rd_stb,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data
);
  localparam int HDR   = CW + 1 + AW;
  localparam int FRAME = HDR + DW;
  localparam int CNT_W = $clog2(FRAME + 1);

  logic [SYNC_STAGES:0]   sck_sr;
  logic [SYNC_STAGES-1:0] cs_sr;
  logic [SYNC_STAGES-1:0] sdi_sr;
  logic cs_q, sdi_q, sck_rise, sck_fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_sr <= '1;
      cs_sr  <= '1;
      sdi_sr <= '0;
    end else begin
      sck_sr <= {sck_sr[SYNC_STAGES-1:0], sck};
      cs_sr  <= {cs_sr[SYNC_STAGES-2:0], cs_n};
      sdi_sr <= {sdi_sr[SYNC_STAGES-2:0], sdi};
    end

  assign cs_q     = cs_sr[SYNC_STAGES-1];
  assign sdi_q    = sdi_sr[SYNC_STAGES-1];
  assign sck_rise =  sck_sr[SYNC_STAGES-1] & ~sck_sr[SYNC_STAGES];
  assign sck_fall = ~sck_sr[SYNC_STAGES-1] &  sck_sr[SYNC_STAGES];

  logic [FRAME-1:0] shreg;
  logic [FRAME-1:0] word_nx;
  logic [CNT_W-1:0] cnt;
  logic [DW-1:0]    tx;
  logic             rd_flag;

  assign word_nx = {shreg[FRAME-2:0], sdi_q};

  logic [CW-1:0] hdr_chip, full_chip;
  logic          hdr_rw, full_rw;
  logic [AW-1:0] hdr_addr, full_addr;
  assign hdr_chip  = word_nx[HDR-1 -: CW];
  assign hdr_rw    = word_nx[AW];
  assign hdr_addr  = word_nx[AW-1:0];
  assign full_chip = word_nx[FRAME-1 -: CW];
  assign full_rw   = word_nx[DW+AW];
  assign full_addr = word_nx[DW+AW-1:DW];

  logic at_hdr, at_end, in_data;
  assign at_hdr  = sck_rise && cnt == CNT_W'(HDR - 1);
  assign at_end  = sck_rise && cnt == CNT_W'(FRAME - 1);
  assign in_data = cnt >= CNT_W'(HDR) && cnt < CNT_W'(FRAME);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg   <= '0;
      cnt     <= '0;
      tx      <= '0;
      rd_flag <= 1'b0;
      sdo     <= 1'b0;
      sdo_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      rd_stb  <= 1'b0;
      rd_addr <= '0;
    end else begin
      wr_stb <= 1'b0;
      rd_stb <= 1'b0;
      if (cs_q) begin
        cnt     <= '0;
        rd_flag <= 1'b0;
        sdo_oe  <= 1'b0;
      end else begin
        if (sck_rise && cnt < CNT_W'(FRAME)) begin
          shreg <= word_nx;
          cnt   <= cnt + 1'b1;
        end
        if (at_hdr && hdr_chip == CW'(CHIP_ID) && !hdr_rw) begin
          rd_stb  <= 1'b1;
          rd_addr <= hdr_addr;
          rd_flag <= 1'b1;
        end
        if (at_end && full_chip == CW'(CHIP_ID) && full_rw &&
            full_addr <= AW'(TOP_WRITABLE)) begin
          wr_stb  <= 1'b1;
          wr_addr <= full_addr;
          wr_data <= word_nx[DW-1:0];
        end
        if (rd_stb)
          tx <= rd_data;
        else if (sck_fall && rd_flag && in_data) begin
          sdo    <= tx[DW-1];
          tx     <= {tx[DW-2:0], 1'b0};
          sdo_oe <= 1'b1;
        end
      end
    end
endmodule

// File: rtl/sctl_port_chk.sv
module sctl_port_chk #(
  parameter int AW           = 5,
  parameter int TOP_WRITABLE = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_q,
  input logic          rd_flag,
  input logic          sdo_oe,
  input logic          wr_stb,
  input logic [AW-1:0] wr_addr,
  input logic          rd_stb
);
  assert_single_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  assert_single_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb);
  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && rd_stb));
  assert_wr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> wr_addr <= AW'(TOP_WRITABLE));
  assert_oe_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |=> !sdo_oe);
  assert_oe_only_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> rd_flag);
  assert_abort_no_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |=> !wr_stb);
endmodule

bind sctl_port sctl_port_chk #(.AW(AW), .TOP_WRITABLE(TOP_WRITABLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .rd_flag(rd_flag), .sdo_oe(sdo_oe),
  .wr_stb(wr_stb), .wr_addr(wr_addr), .rd_stb(rd_stb)
);

// File: tb/sctl_port_tb.sv
module sctl_port_tb_top;
  localparam int HALF = 100;
  localparam int SYNC = 2;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe, wr_stb, rd_stb;
  logic [4:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;

  always #2 clk = ~clk;

  sctl_port dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  logic [7:0] bank [32];
  logic [7:0] expm [32];
  int wr_cnt = 0, rd_cnt = 0;
  int vectors = 0, misses = 0;
  logic [4:0] last_wa, last_ra;
  logic [7:0] last_wd;

  assign rd_data = bank[rd_addr];

  always @(negedge clk) begin
    if (wr_stb) begin
      wr_cnt  <= wr_cnt + 1;
      last_wa <= wr_addr;
      last_wd <= wr_data;
      bank[wr_addr] <= wr_data;
    end
    if (rd_stb) begin
      rd_cnt  <= rd_cnt + 1;
      last_ra <= rd_addr;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fr(input logic [1:0] c, input logic rw,
                                     input logic [4:0] a, input logic [7:0] d);
    return {c, rw, a, d};
  endfunction

  int pre_last, post_last, oe_hdr, oe_any;
  logic [7:0] rb;

  task automatic xfer(input logic [15:0] w, input int nbits);
    rb = '0; oe_hdr = 0; oe_any = 0;
    pre_last = wr_cnt; post_last = wr_cnt;
    cs_n = 1'b0;
    #(HALF);
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b0;
      sdi = (i < 16) ? w[15-i] : 1'b0;
      #(HALF);
      if (i == 15) pre_last = wr_cnt;
      sck = 1'b1;
      if (i < 8 && sdo_oe) oe_hdr++;
      if (sdo_oe) oe_any++;
      if (i >= 8 && i < 16) rb = {rb[6:0], sdo};
      if (i == 15) begin
        repeat (SYNC + 3) @(negedge clk);
        post_last = wr_cnt;
        #(HALF - 4 * (SYNC + 3));
      end else
        #(HALF);
    end
    cs_n = 1'b1;
    repeat (SYNC + 2) @(negedge clk);
    chk(sdo_oe == 1'b0, "R5 oe released after select high", sdo_oe, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(wr_stb == 0 && rd_stb == 0, "R9 strobes low after reset", {wr_stb, rd_stb}, 0);
    chk(sdo_oe == 0, "R9 oe low after reset", sdo_oe, 0);
  endtask

  task automatic t_write(input logic [4:0] a, input logic [7:0] d);
    int w0;
    w0 = wr_cnt;
    xfer(fr(2'b00, 1'b1, a, d), 16);
    expm[a] = d;
    chk(pre_last == w0, "R1 no write before 16th edge", pre_last - w0, 0);
    chk(post_last == w0 + 1, "R1 write strobe after 16th edge", post_last - w0, 1);
    chk(last_wa == a && last_wd == d, "R1 write address/data", {last_wa, last_wd}, {a, d});
    chk(oe_any == 0, "R5 no drive in write frame", oe_any, 0);
  endtask

  task automatic t_read(input logic [4:0] a);
    int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    xfer(fr(2'b00, 1'b0, a, 8'h00), 16);
    chk(rd_cnt == r0 + 1 && last_ra == a, "R3 one read strobe with address", last_ra, a);
    chk(wr_cnt == w0, "R3 read issues no write", wr_cnt - w0, 0);
    chk(rb == expm[a], "R4 read data MSB first", rb, expm[a]);
    chk(oe_hdr == 0, "R5 no drive in header phase", oe_hdr, 0);
  endtask

  task automatic t_bad_chip;
    int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    xfer(fr(2'b01, 1'b1, 5'h03, 8'hEE), 16);
    xfer(fr(2'b10, 1'b0, 5'h03, 8'h00), 16);
    chk(oe_any == 0, "R2 no drive for foreign chip", oe_any, 0);
    xfer(fr(2'b11, 1'b1, 5'h03, 8'h11), 16);
    chk(wr_cnt == w0 && rd_cnt == r0, "R2 foreign chip ignored", wr_cnt - w0 + rd_cnt - r0, 0);
    t_read(5'h03);
  endtask

  task automatic t_protected;
    int w0;
    w0 = wr_cnt;
    xfer(fr(2'b00, 1'b1, 5'h12, 8'h5A), 16);
    xfer(fr(2'b00, 1'b1, 5'h1F, 8'hA5), 16);
    chk(wr_cnt == w0, "R6 writes above 11h suppressed", wr_cnt - w0, 0);
    t_read(5'h12);
    t_read(5'h1F);
    t_write(5'h11, 8'h3C);
    t_read(5'h11);
  endtask

  task automatic t_abort;
    int w0;
    w0 = wr_cnt;
    xfer(fr(2'b00, 1'b1, 5'h04, 8'hF0), 15);
    chk(wr_cnt == w0, "R7 short frame writes nothing", wr_cnt - w0, 0);
    t_read(5'h04);
  endtask

  task automatic t_overclock;
    int w0;
    w0 = wr_cnt;
    xfer(fr(2'b00, 1'b1, 5'h06, 8'h81), 24);
    expm[6] = 8'h81;
    chk(wr_cnt == w0 + 1, "R8 one strobe despite extra clocks", wr_cnt - w0, 1);
    chk(last_wd == 8'h81, "R8 data unaffected by extra clocks", last_wd, 8'h81);
  endtask

  bit done = 0;
  initial begin
    for (int i = 0; i < 32; i++) begin
      bank[i] = 8'(i * 37 + 5);
      expm[i] = 8'(i * 37 + 5);
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_write(5'h01, 8'hA5);
    t_read(5'h01);
    t_write(5'h00, 8'h01);
    t_write(5'h10, 8'h80);
    t_read(5'h00);
    t_read(5'h10);
    t_read(5'h09);
    t_bad_chip();
    t_protected();
    t_abort();
    t_overclock();
    t_read(5'h06);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule